// File: doc/BRIEF.md
# Timekeeping Rate Correction Injector

This block sits between a sub-second prescaler and a calendar counter. It counts prescaler steps and emits one seconds tick per second. When a rate correction is programmed, some seconds are made one step shorter or one step longer. This pulls the long-term rate of the calendar up or down. The correction comes from an 8-bit configuration byte. Its low seven bits are a signed two's-complement amount, and its top bit selects between two modes:
- In fine mode, the correction applies only in hours of even parity.
- In coarse mode, the same schedule applies in every hour, which doubles the weight of each unit.

The calendar supplies the current second, the current minute and the hour parity. The block uses these to decide whether the second now starting is a corrected one. A correction amount of magnitude m affects the opening second of minutes 0 through m-1. Amounts beyond 59 cannot be spread further, so their surplus piles into the final minute of the hour. That minute then uses its opening seconds, one correction per second. A new configuration byte is adopted only at the top of an hour, so a schedule is never switched partway through.

Top module: `offs_corr_inject`

## Requirements
- R1: After reset no correction is active, secTick is low, and every second lasts exactly STEPS_PER_SEC steps.
- R2: With a correction amount of 0, every second lasts STEPS_PER_SEC steps in both modes.
- R3: offsetCfg is decoded as follows:
  - Bits 6:0 are a two's-complement amount, with bit 6 as its sign.
  - Bit 7 set selects coarse mode; clear selects fine mode.
  - A second is never both shortened and lengthened.
- R4: A positive amount shortens each selected second to STEPS_PER_SEC-1 steps.
- R5: A negative amount lengthens each selected second to STEPS_PER_SEC+1 steps.
- R6: With magnitude m, second 0 of each minute k < 59 with k < m is selected. Seconds other than those named in R6 and R7 are never selected.
- R7: When m > 59, seconds 0 through m-60 of minute 59 are selected (for example, m=64 gives seconds 0 to 4). When m ≤ 59, no second of minute 59 is selected.
- R8: In fine mode, corrections apply only while hourOdd is 0. In coarse mode, they apply regardless of hourOdd.
- R9: offsetCfg is adopted only on the first step of a second in which minNow and secNow are both 0. That second already uses the new value; every other second uses the last adopted value.
- R10: secTick is high only in a cycle where stepPulse is high, namely the cycle of the final step of a second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stepPulse | input | 1 | One-cycle sub-second step from the prescaler |
| secNow | input | 6 | Current second of the minute from the calendar (0..59) |
| minNow | input | 6 | Current minute of the hour from the calendar (0..59) |
| hourOdd | input | 1 | Parity of the current hour (1 = odd) |
| offsetCfg | input | 8 | Configuration byte: bit 7 coarse mode, bits 6:0 signed amount |
| secTick | output | 1 | Adjusted seconds tick to the calendar, high during the last step |

## Verification
The length of individual seconds is measured in steps at chosen calendar positions. The bench uses zero, small positive, small negative, and the extreme amounts +63 and -64. Positive and negative amounts tell the shortening and lengthening paths apart. Running the same amount in both hour parities and both modes separates fine scheduling from coarse scheduling. Probing minutes 58 and 59 across their opening seconds checks the fold of large amounts. Writing a new byte in mid-hour and measuring before and after the next hour start shows that adoption waits for the hour boundary.

// File: rtl/offs_pkg.sv
package offs_pkg;
  // Strobes from the scheduler to the step datapath, valid at a second's first step
  typedef struct packed {
    logic loadCfg;   // adopt the pending configuration byte
    logic shortSec;  // this second loses one step
    logic longSec;   // this second gains one step
  } corrStrobe_t;

  localparam int unsigned MINUTE_LAST = 59;
endpackage

// File: rtl/offs_sched.sv
module offs_sched
  import offs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [5:0]  secNow,
  input  logic [5:0]  minNow,
  input  logic        hourOdd,
  input  logic [7:0]  offsetCfg,
  input  logic [7:0]  activeCfg,
  output corrStrobe_t strb
);
  logic       hourEdge;
  logic [7:0] cfgUse;
  logic       isNeg;
  logic [7:0] mag;
  logic [7:0] minuteCnt;
  logic       hourOk;
  logic       selSec;

  always_comb begin
    hourEdge = (minNow == 6'd0) && (secNow == 6'd0);
    cfgUse   = hourEdge ? offsetCfg : activeCfg;
    isNeg    = cfgUse[6];
    mag      = isNeg ? (8'd128 - {1'b0, cfgUse[6:0]}) : {1'b0, cfgUse[6:0]};
    hourOk   = cfgUse[7] | ~hourOdd;
    if (minNow < 6'(MINUTE_LAST))
      minuteCnt = ({2'b00, minNow} < mag) ? 8'd1 : 8'd0;
    else if (mag > 8'(MINUTE_LAST))
      minuteCnt = mag - 8'(MINUTE_LAST);
    else
      minuteCnt = 8'd0;
    selSec        = hourOk && ({2'b00, secNow} < minuteCnt);
    strb.loadCfg  = hourEdge;
    strb.shortSec = selSec && !isNeg;
    strb.longSec  = selSec && isNeg;
  end

  AST_SIGN_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.shortSec && strb.longSec)); // R3
  AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!hourEdge && activeCfg[6:0] == 7'd0) |-> (!strb.shortSec && !strb.longSec)); // R2
  AST_LATE_SEC_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (secNow >= 6'd5) |-> (!strb.shortSec && !strb.longSec)); // R6
endmodule

// File: rtl/offs_step_dp.sv
module offs_step_dp
  import offs_pkg::*;
#(
  parameter int unsigned STEPS_PER_SEC = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        stepPulse,
  input  logic [7:0]  offsetCfg,
  input  corrStrobe_t strb,
  output logic [7:0]  activeCfg,
  output logic        secTick
);
  localparam int unsigned CW = $clog2(STEPS_PER_SEC + 2) + 1;

  logic [CW-1:0] stepCnt;
  logic [CW-1:0] lastIdx;
  logic          corrShort;
  logic          corrLong;
  logic          atStart;
  logic          useShort;
  logic          useLong;

  always_comb begin
    atStart  = (stepCnt == '0);
    useShort = atStart ? strb.shortSec : corrShort;
    useLong  = atStart ? strb.longSec  : corrLong;
    if (useShort)
      lastIdx = CW'(STEPS_PER_SEC - 2);
    else if (useLong)
      lastIdx = CW'(STEPS_PER_SEC);
    else
      lastIdx = CW'(STEPS_PER_SEC - 1);
    secTick = stepPulse && (stepCnt == lastIdx);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepCnt   <= '0;
      corrShort <= 1'b0;
      corrLong  <= 1'b0;
      activeCfg <= 8'h00;
    end else if (stepPulse) begin
      stepCnt <= secTick ? '0 : stepCnt + 1'b1;
      if (atStart) begin
        corrShort <= strb.shortSec;
        corrLong  <= strb.longSec;
        if (strb.loadCfg)
          activeCfg <= offsetCfg;
      end
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(stepPulse && atStart && strb.loadCfg) |=> $stable(activeCfg)); // R9
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    secTick |-> (stepCnt >= CW'(STEPS_PER_SEC - 2) && stepCnt <= CW'(STEPS_PER_SEC))); // R4
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rstN)
    stepCnt <= CW'(STEPS_PER_SEC)); // R5
endmodule

// File: rtl/offs_corr_inject.sv
module offs_corr_inject
  import offs_pkg::*;
#(
  parameter int unsigned STEPS_PER_SEC = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       stepPulse,
  input  logic [5:0] secNow,
  input  logic [5:0] minNow,
  input  logic       hourOdd,
  input  logic [7:0] offsetCfg,
  output logic       secTick
);
  corrStrobe_t strb;
  logic [7:0]  activeCfg;

  offs_sched uSched (
    .clk       (clk),
    .rstN      (rstN),
    .secNow    (secNow),
    .minNow    (minNow),
    .hourOdd   (hourOdd),
    .offsetCfg (offsetCfg),
    .activeCfg (activeCfg),
    .strb      (strb)
  );

  offs_step_dp #(.STEPS_PER_SEC(STEPS_PER_SEC)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .stepPulse (stepPulse),
    .offsetCfg (offsetCfg),
    .strb      (strb),
    .activeCfg (activeCfg),
    .secTick   (secTick)
  );

  AST_TICK_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rstN)
    secTick |-> stepPulse); // R10
endmodule

// File: tb/tb_offs_corr_inject.sv
module tb_offs_corr_inject;
  localparam int CLK_PERIOD = 10;
  localparam int STEPS = 8;

  logic       clk = 1'b0;
  logic       rstN;
  logic       stepPulse;
  logic [5:0] secNow;
  logic [5:0] minNow;
  logic       hourOdd;
  logic [7:0] offsetCfg;
  logic       secTick;

  int nCmp = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  offs_corr_inject #(.STEPS_PER_SEC(STEPS)) dut (
    .clk(clk), .rstN(rstN), .stepPulse(stepPulse), .secNow(secNow),
    .minNow(minNow), .hourOdd(hourOdd), .offsetCfg(offsetCfg), .secTick(secTick)
  );

  task automatic check(input string req, input int got, input int exp);
    nCmp++;
    if (got != exp) begin
      nBad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // Runs one second at the given calendar position and returns its length in steps
  task automatic runSecond(input int m, input int s, input bit hOdd, input bit [7:0] cfg,
                           output int len, output int strayTicks);
    len = 0;
    strayTicks = 0;
    @(negedge clk);
    minNow = 6'(m); secNow = 6'(s); hourOdd = hOdd; offsetCfg = cfg;
    for (int i = 0; i < STEPS + 4; i++) begin
      @(negedge clk);
      stepPulse = 1'b1;
      #1;
      len++;
      if (secTick) begin
        @(negedge clk);
        stepPulse = 1'b0;
        #1;
        if (secTick) strayTicks++;
        break;
      end
      @(negedge clk);
      stepPulse = 1'b0;
      #1;
      if (secTick) strayTicks++;
    end
  endtask

  task automatic expectSec(input string req, input int m, input int s, input bit hOdd,
                           input bit [7:0] cfg, input int expLen);
    int len, stray;
    runSecond(m, s, hOdd, cfg, len, stray);
    check(req, len, expLen);
    check("R10", stray, 0);
  endtask

  task automatic testReset();
    #1;
    check("R1", int'(secTick), 0);
    expectSec("R1", 5, 3, 1'b0, 8'h00, STEPS);
    expectSec("R1", 0, 1, 1'b0, 8'h00, STEPS);
  endtask

  task automatic testZero();
    expectSec("R2", 0, 0, 1'b0, 8'h00, STEPS);
    expectSec("R2", 0, 0, 1'b1, 8'h80, STEPS);
    expectSec("R2", 59, 0, 1'b0, 8'h80, STEPS);
  endtask

  task automatic testPositiveFine();
    expectSec("R4", 0, 0, 1'b0, 8'h03, STEPS - 1);
    expectSec("R6", 1, 0, 1'b0, 8'h03, STEPS - 1);
    expectSec("R6", 2, 0, 1'b0, 8'h03, STEPS - 1);
    expectSec("R6", 3, 0, 1'b0, 8'h03, STEPS);
    expectSec("R6", 1, 1, 1'b0, 8'h03, STEPS);
    expectSec("R7", 59, 0, 1'b0, 8'h03, STEPS);
  endtask

  task automatic testOddHourFine();
    expectSec("R8", 0, 0, 1'b1, 8'h03, STEPS);
    expectSec("R8", 1, 0, 1'b1, 8'h03, STEPS);
  endtask

  task automatic testNegativeCoarse();
    expectSec("R5", 0, 0, 1'b1, 8'hFE, STEPS + 1);
    expectSec("R8", 1, 0, 1'b1, 8'hFE, STEPS + 1);
    expectSec("R3", 2, 0, 1'b1, 8'hFE, STEPS);
    expectSec("R8", 1, 0, 1'b0, 8'hFE, STEPS + 1);
  endtask

  task automatic testFold();
    expectSec("R7", 0, 0, 1'b0, 8'h3F, STEPS - 1);
    expectSec("R7", 58, 0, 1'b0, 8'h3F, STEPS - 1);
    expectSec("R7", 59, 0, 1'b0, 8'h3F, STEPS - 1);
    expectSec("R7", 59, 3, 1'b0, 8'h3F, STEPS - 1);
    expectSec("R7", 59, 4, 1'b0, 8'h3F, STEPS);
    expectSec("R7", 0, 0, 1'b0, 8'h40, STEPS + 1);
    expectSec("R7", 59, 4, 1'b0, 8'h40, STEPS + 1);
    expectSec("R7", 59, 5, 1'b0, 8'h40, STEPS);
    expectSec("R6", 58, 1, 1'b0, 8'h40, STEPS);
  endtask

  task automatic testHourAdoption();
    expectSec("R9", 0, 0, 1'b0, 8'h03, STEPS - 1);
    expectSec("R9", 1, 0, 1'b0, 8'h00, STEPS - 1);
    expectSec("R9", 2, 0, 1'b0, 8'hFD, STEPS - 1);
    expectSec("R9", 0, 0, 1'b0, 8'h00, STEPS);
    expectSec("R9", 1, 0, 1'b0, 8'h00, STEPS);
  endtask

  initial begin
    rstN = 1'b0; stepPulse = 1'b0; secNow = '0; minNow = '0;
    hourOdd = 1'b0; offsetCfg = 8'h00;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testZero();
    testPositiveFine();
    testOddHourFine();
    testNegativeCoarse();
    testFold();
    testHourAdoption();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule